// File: doc/BRIEF.md
# I2C Write-Command Target with Acknowledge Policy

This block is the receive front end of an I2C target. It samples the SCL and SDA lines with the system clock. Each line passes through a two-flop synchronizer and then a two-sample agreement filter. The block recognises Start, Repeated Start and Stop conditions and shifts in bytes MSB first on rising SCL edges. After each byte it decides whether to pull SDA low for the ninth clock. Only write transfers with 7-bit addressing are handled.

The first byte after a Start is the address byte: seven address bits followed by the direction bit in bit 0. The block acknowledges it in two cases. The first is a match with its own address, the fixed five-bit prefix `TARGET_PREFIX` followed by the two `addr_pins`, with the direction bit at 0 (write). The second is the all-zero general-call address, but only while `gc_en` is high. Every byte after an acknowledged address is a command byte. A command byte is shown on `cmd_byte` together with a one-cycle `cmd_strobe`, and the downstream register block answers on `cmd_valid` in that same cycle. The command is acknowledged only when the verdict is valid and `nv_busy` (a nonvolatile write in progress) is low. Any refusal parks the controller until the next Start.

The controller has six states. IDLE waits for a Start. ADDR shifts in the address byte. ADDR_ACK drives the address acknowledge. CMD shifts in a command byte. CMD_ACK drives the command acknowledge. HOLD ignores the bus after a refusal. The transitions are as follows:
- A Start, from any state, goes to ADDR.
- A Stop, from any state, goes to IDLE.
- ADDR goes to ADDR_ACK when the address is accepted and to HOLD when it is refused, on the SCL fall after the eighth bit.
- ADDR_ACK goes to CMD on the SCL fall that ends the ninth clock.
- CMD goes to CMD_ACK when the command is accepted and to HOLD when it is refused, on the SCL fall after the eighth bit.
- CMD_ACK goes to CMD on the SCL fall that ends the ninth clock.

Top module: `i2c_ack_target`

## Requirements
- R1: A falling SDA while SCL is high is a Start. From any state, including in the middle of a frame, it restarts reception with a fresh address byte.
- R2: A rising SDA while SCL is high is a Stop. It returns the controller to IDLE, and clocks that follow it without a new Start are never acknowledged.
- R3: Bits are taken on rising SCL, MSB first. An address byte equal to {TARGET_PREFIX, addr_pins, 0} is acknowledged: `sda_oe` is high through the ninth SCL pulse.
- R4: An address byte that is neither this target's address nor an enabled general call is not acknowledged. No later byte of that frame is acknowledged or strobed.
- R5: The address byte 0x00 is acknowledged when `gc_en` is 1 and refused when it is 0.
- R6: A read-direction address byte (bit 0 = 1) is refused. Any byte whose top five bits are 11110 (the 10-bit prefix) is refused.
- R7: Each byte after an acknowledged address is presented on `cmd_byte` with `cmd_strobe` high for exactly one cycle. It is acknowledged exactly when `cmd_valid` is 1 in that cycle.
- R8: While `nv_busy` is 1, a matching address is still acknowledged, but the command byte that follows is refused.
- R9: After any refusal, no byte is acknowledged or strobed until a new Start. After that Start, reception works normally again.
- R10: A pulse lasting a single system clock on SCL or on SDA has no effect on reception.
- R11: Out of reset, `sda_oe` and `cmd_strobe` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Raw SCL line level |
| sda_i | input | 1 | Raw SDA line level |
| sda_oe | output | 1 | Open-drain enable; 1 pulls SDA low |
| addr_pins | input | 2 | Low two bits of the target address |
| gc_en | input | 1 | Enables acknowledge of the general-call address |
| nv_busy | input | 1 | Nonvolatile write in progress; refuses commands |
| cmd_byte | output | 8 | Most recently received byte |
| cmd_strobe | output | 1 | One-cycle pulse when a command byte is complete |
| cmd_valid | input | 1 | Verdict on `cmd_byte`, valid while `cmd_strobe` is high |

## Verification
The assertions assume that the bus follows the protocol. SDA changes only while SCL is low, except to form a Start or a Stop. No Start or Stop is placed inside an acknowledge clock, so a release of `sda_oe` can only follow a falling SCL. They also assume that `cmd_valid` and `nv_busy` are settled in the cycle of `cmd_strobe`. The stimulus keeps to this in the following ways:
- Every SDA change is delayed by half a quarter-period after SCL falls.
- Each quarter-period is long compared with the filter latency.
- `cmd_valid` is derived combinationally from `cmd_byte`.
- The only violations are deliberate single-clock glitches, which the filter must absorb.

// File: rtl/i2ct_pkg.sv
package i2ct_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_CMD,
        ST_CMD_ACK,
        ST_HOLD
    } tgt_state_t;
endpackage

// File: rtl/i2ct_line_filter.sv
module i2ct_line_filter #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw,
    output logic filt
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   last_q;

    // Synchronizer chain, then a value is accepted once two samples agree.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            last_q <= 1'b1;
            filt   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw};
            last_q <= sync_q[SYNC_STAGES-1];
            if (sync_q[SYNC_STAGES-1] == last_q)
                filt <= last_q;
        end
    end
endmodule

// File: rtl/i2ct_bus_events.sv
module i2ct_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_f,
    input  logic sda_f,
    output logic start_det,
    output logic stop_det,
    output logic scl_rise,
    output logic scl_fall
);
    logic scl_q, sda_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_f;
            sda_q <= sda_f;
        end
    end

    always_comb begin
        start_det = scl_q && scl_f && sda_q && !sda_f;
        stop_det  = scl_q && scl_f && !sda_q && sda_f;
        scl_rise  = !scl_q && scl_f;
        scl_fall  = scl_q && !scl_f;
    end
endmodule

// File: rtl/i2ct_ctrl.sv
module i2ct_ctrl
    import i2ct_pkg::*;
#(
    parameter logic [4:0] TARGET_PREFIX = 5'b01011,
    parameter int         PIN_BITS      = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_det,
    input  logic                stop_det,
    input  logic                scl_rise,
    input  logic                scl_fall,
    input  logic                sda_f,
    input  logic [PIN_BITS-1:0] addr_pins,
    input  logic                gc_en,
    input  logic                nv_busy,
    input  logic                cmd_valid,
    output logic                sda_oe,
    output logic                cmd_strobe,
    output logic [7:0]          cmd_byte
);
    localparam int BYTE_W = 8;
    localparam int ADDR_W = $bits(TARGET_PREFIX) + PIN_BITS;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    tgt_state_t        state_q, state_d;
    logic [BYTE_W-1:0] shift_q;
    logic [CNT_W-1:0]  bit_cnt_q;
    logic              byte_done;
    logic              own_hit, gc_hit, ten_bit, addr_ok, shifting;

    assign shifting  = (state_q == ST_ADDR) || (state_q == ST_CMD);
    assign byte_done = scl_fall && (bit_cnt_q == CNT_W'(BYTE_W));

    // Address policy on the completed address byte.
    always_comb begin
        own_hit = (shift_q[BYTE_W-1:1] == {TARGET_PREFIX, addr_pins}) && !shift_q[0];
        gc_hit  = (shift_q[BYTE_W-1:1] == '0) && !shift_q[0] && gc_en;
        ten_bit = (shift_q[BYTE_W-1:BYTE_W-5] == 5'b11110);
        addr_ok = (own_hit || gc_hit) && !ten_bit;
    end

    // Shift register and bit counter.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shift_q   <= '0;
            bit_cnt_q <= '0;
        end else if (start_det) begin
            bit_cnt_q <= '0;
        end else if (scl_rise && shifting && bit_cnt_q != CNT_W'(BYTE_W)) begin
            shift_q   <= {shift_q[BYTE_W-2:0], sda_f};
            bit_cnt_q <= bit_cnt_q + 1'b1;
        end else if (scl_fall && (state_q == ST_ADDR_ACK || state_q == ST_CMD_ACK)) begin
            bit_cnt_q <= '0;
        end
    end

    // State register.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        if (start_det) begin
            state_d = ST_ADDR;
        end else if (stop_det) begin
            state_d = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:     state_d = ST_IDLE;
                ST_ADDR:     if (byte_done) state_d = addr_ok ? ST_ADDR_ACK : ST_HOLD;
                ST_ADDR_ACK: if (scl_fall) state_d = ST_CMD;
                ST_CMD:      if (byte_done) state_d = (cmd_valid && !nv_busy) ? ST_CMD_ACK : ST_HOLD;
                ST_CMD_ACK:  if (scl_fall) state_d = ST_CMD;
                ST_HOLD:     state_d = ST_HOLD;
                default:     state_d = ST_IDLE;
            endcase
        end
    end

    // Outputs.
    always_comb begin
        sda_oe     = (state_q == ST_ADDR_ACK) || (state_q == ST_CMD_ACK);
        cmd_strobe = (state_q == ST_CMD) && byte_done;
        cmd_byte   = shift_q;
    end

    logic unused_w;
    assign unused_w = (ADDR_W == 0);
endmodule

// File: rtl/i2c_ack_target.sv
module i2c_ack_target #(
    parameter logic [4:0] TARGET_PREFIX = 5'b01011,
    parameter int         SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic [1:0] addr_pins,
    input  logic       gc_en,
    input  logic       nv_busy,
    output logic [7:0] cmd_byte,
    output logic       cmd_strobe,
    input  logic       cmd_valid
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] line_raw, line_f;
    logic scl_f, sda_f;
    logic start_det, stop_det, scl_rise, scl_fall;

    assign line_raw = {sda_i, scl_i};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        i2ct_line_filter #(.SYNC_STAGES(SYNC_STAGES)) filt_i (
            .clk  (clk),
            .rst_n(rst_n),
            .raw  (line_raw[g]),
            .filt (line_f[g])
        );
    end

    assign scl_f = line_f[0];
    assign sda_f = line_f[1];

    i2ct_bus_events events_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_f    (scl_f),
        .sda_f    (sda_f),
        .start_det(start_det),
        .stop_det (stop_det),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall)
    );

    i2ct_ctrl #(.TARGET_PREFIX(TARGET_PREFIX), .PIN_BITS(2)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_det (start_det),
        .stop_det  (stop_det),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_f     (sda_f),
        .addr_pins (addr_pins),
        .gc_en     (gc_en),
        .nv_busy   (nv_busy),
        .cmd_valid (cmd_valid),
        .sda_oe    (sda_oe),
        .cmd_strobe(cmd_strobe),
        .cmd_byte  (cmd_byte)
    );
endmodule

// File: rtl/i2ct_checker.sv
module i2ct_checker (
    input logic clk,
    input logic rst_n,
    input logic scl_f,
    input logic scl_fall,
    input logic stop_det,
    input logic sda_oe,
    input logic cmd_strobe,
    input logic cmd_valid,
    input logic nv_busy
);
    a_r7_strobe_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_strobe |=> !cmd_strobe);

    a_r7_invalid_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && !cmd_valid) |=> !sda_oe);

    a_r8_busy_refused: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_strobe && nv_busy) |=> !sda_oe);

    a_r2_stop_releases: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!sda_oe && !cmd_strobe));

    a_r3_ack_starts_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> $past(scl_fall));

    a_r3_oe_steady_scl_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_f && $past(scl_f)) |-> $stable(sda_oe));
endmodule

bind i2c_ack_target i2ct_checker chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .scl_f     (scl_f),
    .scl_fall  (scl_fall),
    .stop_det  (stop_det),
    .sda_oe    (sda_oe),
    .cmd_strobe(cmd_strobe),
    .cmd_valid (cmd_valid),
    .nv_busy   (nv_busy)
);

// File: tb/i2c_ack_target_tb.sv
module i2c_ack_target_tb_top;
    localparam int Q = 8;
    localparam int H = 4;
    localparam logic [4:0] PFX = 5'b01011;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic [1:0] addr_pins = 2'b10;
    logic gc_en = 1'b0, nv_busy = 1'b0;
    logic sda_oe, cmd_strobe, cmd_valid;
    logic [7:0] cmd_byte;
    logic sda_bus;

    int errors = 0, checks = 0, strobes = 0;
    logic [7:0] last_cmd = 8'h00;
    bit done = 1'b0;

    always #10 clk = ~clk;

    assign sda_bus = m_sda & ~sda_oe;

    function automatic logic verdict(input logic [7:0] c);
        return (c[7:4] <= 4'hA) && (c[3:2] != 2'b10);
    endfunction

    assign cmd_valid = verdict(cmd_byte);

    i2c_ack_target dut_i (
        .clk(clk), .rst_n(rst_n), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_oe(sda_oe), .addr_pins(addr_pins), .gc_en(gc_en),
        .nv_busy(nv_busy), .cmd_byte(cmd_byte), .cmd_strobe(cmd_strobe),
        .cmd_valid(cmd_valid)
    );

    always @(negedge clk) if (cmd_strobe) begin
        strobes++;
        last_cmd = cmd_byte;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wt(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_start();
        if (!m_scl) begin
            wt(H); m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
        end
        m_sda = 1'b0; wt(Q); m_scl = 1'b0;
    endtask

    task automatic do_stop();
        wt(H); m_sda = 1'b0; wt(Q); m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(2*Q);
    endtask

    task automatic send_byte(input logic [7:0] b, input bit glitch, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            wt(H); m_sda = b[i];
            if (glitch && i == 5) begin
                @(negedge clk) m_scl = 1'b1;
                @(negedge clk) m_scl = 1'b0;
            end
            wt(Q); m_scl = 1'b1; wt(Q);
            if (glitch && i == 5) begin
                m_sda = ~b[i];
                @(negedge clk) m_sda = b[i];
            end
            wt(Q); m_scl = 1'b0;
        end
        wt(H); m_sda = 1'b1; wt(Q); m_scl = 1'b1; wt(Q);
        ack = (sda_bus == 1'b0);
        wt(Q); m_scl = 1'b0;
    endtask

    initial begin
        bit ack, ack2, exp;
        int s0;
        logic [6:0] tgt;
        wt(3);
        check(sda_oe == 1'b0, "R11 sda_oe", sda_oe, 0);
        check(cmd_strobe == 1'b0, "R11 cmd_strobe", cmd_strobe, 0);
        rst_n = 1'b1;
        wt(5);
        tgt = {PFX, addr_pins};

        // Full sweep of write-direction addresses with general call disabled (R3, R4, R5, R6)
        for (int a = 0; a < 128; a++) begin
            exp = (7'(a) == tgt);
            s0 = strobes;
            do_start();
            send_byte({7'(a), 1'b0}, 1'b0, ack);
            if (a == 0) check(ack == 1'b0, "R5 gc disabled", ack, 0);
            else if (a[6:2] == 5'b11110) check(ack == 1'b0, "R6 ten-bit prefix", ack, 0);
            else check(ack == exp, "R3/R4 address ack", ack, exp);
            send_byte(8'h15, 1'b0, ack2);
            check(ack2 == exp, "R4 rest of frame", ack2, exp);
            check((strobes - s0) == int'(exp), "R4 strobes", strobes - s0, int'(exp));
            do_stop();
        end

        // Address pins sweep (R3)
        for (int p = 0; p < 4; p++) begin
            addr_pins = 2'(p);
            for (int q = 0; q < 4; q++) begin
                do_start();
                send_byte({PFX, 2'(q), 1'b0}, 1'b0, ack);
                check(ack == (p == q), "R3 pins match", ack, int'(p == q));
                do_stop();
            end
        end
        addr_pins = 2'b10;

        // General call enabled (R5), read direction (R6)
        gc_en = 1'b1;
        do_start(); send_byte(8'h00, 1'b0, ack); do_stop();
        check(ack == 1'b1, "R5 gc enabled", ack, 1);
        gc_en = 1'b0;
        do_start(); send_byte({tgt, 1'b1}, 1'b0, ack); do_stop();
        check(ack == 1'b0, "R6 read direction", ack, 0);

        // Command verdict sweep (R7)
        for (int i = 0; i < 64; i++) begin
            logic [7:0] c;
            c = {6'(i), 2'(i)};
            s0 = strobes;
            do_start();
            send_byte({tgt, 1'b0}, 1'b0, ack);
            send_byte(c, 1'b0, ack2);
            do_stop();
            check((strobes - s0) == 1, "R7 strobe count", strobes - s0, 1);
            check(last_cmd == c, "R7 cmd_byte", last_cmd, c);
            check(ack2 == verdict(c), "R7 cmd ack", ack2, verdict(c));
        end

        // Busy then refusal hold then repeated start (R8, R9, R1)
        nv_busy = 1'b1;
        do_start();
        send_byte({tgt, 1'b0}, 1'b0, ack);
        check(ack == 1'b1, "R8 addr while busy", ack, 1);
        send_byte(8'h11, 1'b0, ack);
        check(ack == 1'b0, "R8 cmd while busy", ack, 0);
        nv_busy = 1'b0;
        s0 = strobes;
        send_byte(8'h11, 1'b0, ack);
        check(ack == 1'b0 && strobes == s0, "R9 hold after refusal", ack, 0);
        do_start();
        send_byte({tgt, 1'b0}, 1'b0, ack);
        send_byte(8'h11, 1'b0, ack2);
        check(ack && ack2, "R9/R1 repeated start recovers", ack2, 1);
        do_stop();

        // Repeated start after a mismatched address (R1)
        do_start();
        send_byte(8'hA0, 1'b0, ack);
        do_start();
        send_byte({tgt, 1'b0}, 1'b0, ack2);
        check(!ack && ack2, "R1 repeated start", ack2, 1);
        do_stop();

        // Bytes clocked after a Stop with no Start (R2)
        do_start();
        send_byte({tgt, 1'b0}, 1'b0, ack);
        do_stop();
        m_scl = 1'b0;
        send_byte({tgt, 1'b0}, 1'b0, ack);
        check(ack == 1'b0, "R2 no ack after stop", ack, 0);
        m_scl = 1'b1; wt(Q); m_sda = 1'b1; wt(Q);
        check(sda_oe == 1'b0, "R2 idle after stop", sda_oe, 0);

        // Single-clock glitches on SCL and SDA (R10)
        for (int g = 0; g < 2; g++) begin
            logic [7:0] ab;
            ab = (g == 0) ? {tgt, 1'b0} : {tgt ^ 7'h10, 1'b0};
            do_start();
            send_byte(ab, 1'b1, ack);
            do_stop();
            check(ack == (g == 0), "R10 glitch ignored", ack, int'(g == 0));
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (195000) @(negedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule